// File: doc/BRIEF.md
# Shared-Channel Direction Controller

This block decides, cycle by cycle, which of two neighbouring routers may drive one shared bidirectional channel between them. It holds a controller for each end: a "high" end and a "low" end. Each controller sees only its own side's state: whether a flit is queued for the channel, whether that flit closes a packet, and the request and grant lines of the opposite end. From these it produces the in/out select that steers that end's data lines, a per-cycle flit-transfer strobe, and its own request and grant lines toward the peer.

The high end owns the channel after reset. A non-owning end that has a flit queued raises its request one cycle later. The owner hands the channel over only when it is not partway through a packet. The low end gives way to a high-end request at its next packet boundary, even when it has flits of its own queued. The high end gives way when it has nothing queued. It also gives way once it has started a parameterised number of packets while the low end was waiting, so the low end cannot wait for ever. Every reversal puts one cycle between the two owners in which neither end drives.

Top module: `bdl_link_dir_ctrl`

## Requirements
- R1: After reset the high end drives (hi_sel_out=1), the low end receives (lo_sel_out=0), and neither request line is raised.
- R2: hi_sel_out and lo_sel_out are never 1 in the same cycle.
- R3: In the cycle after an end asserts its grant, neither end drives. In the cycle after that, the requesting end drives.
- R4: A non-owning end raises its request exactly one cycle after a cycle in which it had a flit queued. The request stays up until the peer grants.
- R5: A high end that owns the channel, has no packet open and has no flit queued grants a pending low request in that same cycle.
- R6: A low end that owns the channel, has no packet open and sees a high request grants in that cycle. It does not start a packet, even with a flit queued.
- R7: An end never grants while it is partway through a packet, meaning it has sent a flit with tail=0 and has not yet sent the flit with tail=1.
- R8: While the low request is up, the high end starts at most HI_BURST_PKTS packets. At the first packet boundary after that it grants, even with flits queued.
- R9: A flit transfer (x_xfer=1) occurs only when that end drives and has a flit queued. An owner with a flit queued sends it unless it is granting in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hi_has_flit | input | 1 | High end has a flit queued for the channel |
| hi_tail | input | 1 | The queued high-end flit is the last of its packet |
| lo_has_flit | input | 1 | Low end has a flit queued for the channel |
| lo_tail | input | 1 | The queued low-end flit is the last of its packet |
| hi_sel_out | output | 1 | High end data lines set to output |
| hi_xfer | output | 1 | High end sends its queued flit this cycle |
| hi_req | output | 1 | High end requests the channel |
| hi_grant | output | 1 | High end hands the channel to the low end |
| lo_sel_out | output | 1 | Low end data lines set to output |
| lo_xfer | output | 1 | Low end sends its queued flit this cycle |
| lo_req | output | 1 | Low end requests the channel |
| lo_grant | output | 1 | Low end hands the channel to the high end |

## Verification
Directed sequences come first. A low request against a high end that is partway through a packet separates a controller that waits for the packet boundary from one that reverses at once. A high request against a low owner with flits queued shows whether the priority is asymmetric. Back-to-back single-flit high packets against a waiting low end count exactly how many packets the burst limit lets through. Random demand and tail patterns at several densities then compare every output in every cycle against a bench model built from the requirements. This exposes wrong turnaround timing, transfers outside ownership and requests raised at the wrong time.

// File: rtl/bdl_pkg.sv
package bdl_pkg;

   // Per-end controller state
   typedef enum logic [2:0] {
      ST_FREE = 3'd0,   // owns the channel, no packet open
      ST_OUT  = 3'd1,   // owns the channel, packet in progress
      ST_IN   = 3'd2,   // peer owns the channel, no local demand seen
      ST_WAIT = 3'd3,   // peer owns the channel, request raised
      ST_TURN = 3'd4    // grant received, dead cycle before driving
   } end_state_e;

endpackage

// File: rtl/bdl_burst_limiter.sv
module bdl_burst_limiter #(
   parameter int unsigned LIMIT = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic peer_req,
   input  logic head_start,
   output logic limit_hit
);
   localparam int unsigned CW = $clog2(LIMIT + 1);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!peer_req) begin
         cnt_q <= '0;
      end else if (head_start && !limit_hit) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign limit_hit = (cnt_q >= CW'(LIMIT));

endmodule

// File: rtl/bdl_end_fsm.sv
module bdl_end_fsm
   import bdl_pkg::*;
#(
   parameter bit          IS_HIGH       = 1'b1,
   parameter int unsigned HI_BURST_PKTS = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic has_flit,
   input  logic tail,
   input  logic peer_req,
   input  logic peer_grant,
   output logic sel_out,
   output logic xfer,
   output logic req,
   output logic grant
);
   localparam end_state_e RST_ST = IS_HIGH ? ST_FREE : ST_IN;

   end_state_e st_q, st_d;
   logic       yield_now;

   generate
      if (IS_HIGH) begin : g_high
         logic limit_hit;
         logic head_start;
         assign head_start = (st_q == ST_FREE) && xfer;
         bdl_burst_limiter #(.LIMIT(HI_BURST_PKTS)) lim_i (
            .clk        (clk),
            .rst_n      (rst_n),
            .peer_req   (peer_req),
            .head_start (head_start),
            .limit_hit  (limit_hit)
         );
         // high end yields only when idle or after its burst allowance
         assign yield_now = peer_req && (!has_flit || limit_hit);
      end else begin : g_low
         // low end yields at every packet boundary when asked
         assign yield_now = peer_req;
      end
   endgenerate

   always_comb begin
      st_d  = st_q;
      xfer  = 1'b0;
      grant = 1'b0;
      unique case (st_q)
         ST_FREE: begin
            if (yield_now) begin
               grant = 1'b1;
               st_d  = ST_IN;
            end else if (has_flit) begin
               xfer = 1'b1;
               if (!tail) st_d = ST_OUT;
            end
         end
         ST_OUT: begin
            if (has_flit) begin
               xfer = 1'b1;
               if (tail) st_d = ST_FREE;
            end
         end
         ST_IN:   if (has_flit) st_d = ST_WAIT;
         ST_WAIT: if (peer_grant) st_d = ST_TURN;
         ST_TURN: st_d = ST_FREE;
         default: st_d = RST_ST;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) st_q <= RST_ST;
      else        st_q <= st_d;
   end

   assign sel_out = (st_q == ST_FREE) || (st_q == ST_OUT);
   assign req     = (st_q == ST_WAIT);

endmodule

// File: rtl/bdl_link_dir_ctrl.sv
module bdl_link_dir_ctrl #(
   parameter int unsigned HI_BURST_PKTS = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic hi_has_flit,
   input  logic hi_tail,
   input  logic lo_has_flit,
   input  logic lo_tail,
   output logic hi_sel_out,
   output logic hi_xfer,
   output logic hi_req,
   output logic hi_grant,
   output logic lo_sel_out,
   output logic lo_xfer,
   output logic lo_req,
   output logic lo_grant
);
   generate
      if (HI_BURST_PKTS < 1) begin : g_bad_burst
         $error("HI_BURST_PKTS must be at least 1");
      end
      if (HI_BURST_PKTS > 1024) begin : g_big_burst
         $error("HI_BURST_PKTS must not exceed 1024");
      end
   endgenerate

   bdl_end_fsm #(.IS_HIGH(1'b1), .HI_BURST_PKTS(HI_BURST_PKTS)) hi_end_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .has_flit   (hi_has_flit),
      .tail       (hi_tail),
      .peer_req   (lo_req),
      .peer_grant (lo_grant),
      .sel_out    (hi_sel_out),
      .xfer       (hi_xfer),
      .req        (hi_req),
      .grant      (hi_grant)
   );

   bdl_end_fsm #(.IS_HIGH(1'b0), .HI_BURST_PKTS(HI_BURST_PKTS)) lo_end_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .has_flit   (lo_has_flit),
      .tail       (lo_tail),
      .peer_req   (hi_req),
      .peer_grant (hi_grant),
      .sel_out    (lo_sel_out),
      .xfer       (lo_xfer),
      .req        (lo_req),
      .grant      (lo_grant)
   );

endmodule

// File: rtl/bdl_link_chk.sv
module bdl_link_chk #(
   parameter int unsigned HI_BURST_PKTS = 2
) (
   input logic clk,
   input logic rst_n,
   input logic hi_has_flit,
   input logic hi_tail,
   input logic lo_has_flit,
   input logic lo_tail,
   input logic hi_sel_out,
   input logic hi_xfer,
   input logic hi_req,
   input logic hi_grant,
   input logic lo_sel_out,
   input logic lo_xfer,
   input logic lo_req,
   input logic lo_grant
);
   logic hi_in_pkt, lo_in_pkt;
   int   hi_heads;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hi_in_pkt <= 1'b0;
         lo_in_pkt <= 1'b0;
         hi_heads  <= 0;
      end else begin
         if (hi_xfer) hi_in_pkt <= !hi_tail;
         if (lo_xfer) lo_in_pkt <= !lo_tail;
         if (!lo_req)                     hi_heads <= 0;
         else if (hi_xfer && !hi_in_pkt)  hi_heads <= hi_heads + 1;
      end
   end

   // R2
   excl_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(hi_sel_out && lo_sel_out));

   // R3
   hi_turn_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hi_grant |=> (!hi_sel_out && !lo_sel_out) ##1 lo_sel_out);

   // R3
   lo_turn_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lo_grant |=> (!hi_sel_out && !lo_sel_out) ##1 hi_sel_out);

   // R4
   lo_req_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lo_req) |-> $past(lo_has_flit));

   // R4
   hi_req_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hi_req) |-> $past(hi_has_flit));

   // R6
   lo_defer_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(hi_req && lo_xfer && !lo_in_pkt));

   // R7
   hi_pkt_whole_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hi_grant |-> !hi_in_pkt);

   // R7
   lo_pkt_whole_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lo_grant |-> !lo_in_pkt);

   // R8
   burst_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hi_heads <= int'(HI_BURST_PKTS));

   // R9
   hi_xfer_own_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hi_xfer |-> (hi_sel_out && hi_has_flit));

   // R9
   lo_xfer_own_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lo_xfer |-> (lo_sel_out && lo_has_flit));

endmodule

bind bdl_link_dir_ctrl bdl_link_chk #(.HI_BURST_PKTS(HI_BURST_PKTS)) chk_i (.*);

// File: tb/bdl_link_dir_ctrl_tb_top.sv
module bdl_link_dir_ctrl_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int BURST      = 2;
   localparam int RAND_CYC   = 4000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic hi_has_flit = 1'b0, hi_tail = 1'b0, lo_has_flit = 1'b0, lo_tail = 1'b0;
   logic hi_sel_out, hi_xfer, hi_req, hi_grant;
   logic lo_sel_out, lo_xfer, lo_req, lo_grant;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   // model state: 0 own-idle, 1 own-in-packet, 2 receive, 3 requesting, 4 turnaround
   int m_hi, m_lo, m_cnt;

   always #(CLK_PERIOD/2) clk = ~clk;

   bdl_link_dir_ctrl #(.HI_BURST_PKTS(BURST)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .hi_has_flit(hi_has_flit), .hi_tail(hi_tail),
      .lo_has_flit(lo_has_flit), .lo_tail(lo_tail),
      .hi_sel_out(hi_sel_out), .hi_xfer(hi_xfer), .hi_req(hi_req), .hi_grant(hi_grant),
      .lo_sel_out(lo_sel_out), .lo_xfer(lo_xfer), .lo_req(lo_req), .lo_grant(lo_grant)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic int next_st(input int st, input bit g, input bit x,
                                  input bit t, input bit f, input bit pg);
      case (st)
         0: return g ? 2 : ((x && !t) ? 1 : 0);
         1: return (x && t) ? 0 : 1;
         2: return f ? 3 : 2;
         3: return pg ? 4 : 3;
         default: return 0;
      endcase
   endfunction

   // compare all outputs against the model, then advance the model over the coming edge
   task automatic step();
      bit hq, lq, hy, ly, hg, lg, hx, lx, hs, ls;
      hq = (m_hi == 3);
      lq = (m_lo == 3);
      hy = lq && (!hi_has_flit || (m_cnt >= BURST));
      ly = hq;
      hg = (m_hi == 0) && hy;
      lg = (m_lo == 0) && ly;
      hx = ((m_hi == 0) && !hy && hi_has_flit) || ((m_hi == 1) && hi_has_flit);
      lx = ((m_lo == 0) && !ly && lo_has_flit) || ((m_lo == 1) && lo_has_flit);
      hs = (m_hi <= 1);
      ls = (m_lo <= 1);
      chk(hi_sel_out == hs, "R3 hi_sel_out", hi_sel_out, hs);
      chk(lo_sel_out == ls, "R3 lo_sel_out", lo_sel_out, ls);
      chk(hi_xfer == hx, "R9 hi_xfer", hi_xfer, hx);
      chk(lo_xfer == lx, "R9 lo_xfer", lo_xfer, lx);
      chk(hi_req == hq, "R4 hi_req", hi_req, hq);
      chk(lo_req == lq, "R4 lo_req", lo_req, lq);
      chk(hi_grant == hg, "R5 hi_grant", hi_grant, hg);
      chk(lo_grant == lg, "R6 lo_grant", lo_grant, lg);
      chk(!(hi_sel_out && lo_sel_out), "R2 both drive", int'(hi_sel_out && lo_sel_out), 0);
      if (!lq)                                  m_cnt = 0;
      else if (m_hi == 0 && hx && m_cnt < BURST) m_cnt = m_cnt + 1;
      m_hi = next_st(m_hi, hg, hx, hi_tail, hi_has_flit, lg);
      m_lo = next_st(m_lo, lg, lx, lo_tail, lo_has_flit, hg);
   endtask

   task automatic cycle(input bit hf, input bit ht, input bit lf, input bit lt);
      @(negedge clk);
      hi_has_flit = hf;
      hi_tail     = ht;
      lo_has_flit = lf;
      lo_tail     = lt;
      #(CLK_PERIOD/4);
      step();
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      finish_run();
   end

   initial begin
      int heads;
      bit granted;
      void'($urandom(32'd7331));
      m_hi = 0; m_lo = 2; m_cnt = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #(CLK_PERIOD/4);
      // R1 reset state
      chk(hi_sel_out == 1'b1, "R1 hi_sel_out", hi_sel_out, 1);
      chk(lo_sel_out == 1'b0, "R1 lo_sel_out", lo_sel_out, 0);
      chk(!hi_req && !lo_req, "R1 req lines", int'(hi_req || lo_req), 0);
      step();

      // high starts a packet while low begins to want the channel
      cycle(1, 0, 1, 0);
      cycle(0, 0, 1, 0);
      chk(lo_req == 1'b1, "R4 lo_req after demand", lo_req, 1);
      chk(hi_grant == 1'b0, "R7 no grant mid-packet", hi_grant, 0);
      cycle(1, 1, 1, 0);
      cycle(0, 0, 1, 0);
      chk(hi_grant == 1'b1, "R5 idle high grants", hi_grant, 1);
      cycle(0, 0, 1, 0);
      chk(!hi_sel_out && !lo_sel_out, "R3 dead cycle", int'(hi_sel_out || lo_sel_out), 0);
      cycle(0, 0, 1, 0);
      chk(lo_sel_out == 1'b1, "R3 low drives", lo_sel_out, 1);
      chk(lo_xfer == 1'b1, "R9 low sends", lo_xfer, 1);

      // low packet ends, high requests, low yields despite queued flits
      cycle(1, 0, 1, 1);
      cycle(1, 0, 1, 0);
      chk(lo_grant == 1'b1, "R6 low yields", lo_grant, 1);
      chk(lo_xfer == 1'b0, "R6 low holds flit", lo_xfer, 0);
      cycle(1, 1, 1, 1);

      // back-to-back single-flit high packets against a waiting low end
      heads = 0;
      granted = 1'b0;
      for (int i = 0; i < 12; i++) begin
         cycle(1, 1, 1, 1);
         if (!granted) begin
            if (hi_xfer && lo_req) heads++;
            if (hi_grant) granted = 1'b1;
         end
      end
      chk(heads == BURST, "R8 packets before grant", heads, BURST);
      chk(granted, "R8 grant reached", int'(granted), 1);

      // random traffic at several densities
      for (int seg = 0; seg < 4; seg++) begin
         for (int i = 0; i < RAND_CYC / 4; i++) begin
            cycle(($urandom % 4) < (seg + 1),
                  ($urandom % 3) == 0,
                  ($urandom % 4) < (4 - seg),
                  ($urandom % (seg + 2)) == 0);
         end
      end

      finish_run();
   end

endmodule